// File: doc/BRIEF.md
# Mode-Dependent Packet FIFO Partitioner

This block carves one single-port 256 x 32 RAM into five logical FIFOs. Software can move and resize each FIFO while the block runs. In device mode, transmit slots 0 to 3 serve IN endpoints 0 to 3, one slot per endpoint. In host mode, a periodic/non-periodic select picks the transmit slot: slot 0 holds all periodic traffic (isochronous and interrupt) and slot 1 holds all non-periodic traffic (control and bulk). Slot 4 is the receive FIFO, and both modes use it.

Two requesters share the one RAM port. The push side writes words into a FIFO and the pop side reads them out. Each side names its target with a receive flag, an endpoint index and a periodic select. The block turns that target into a slot for the current mode. It then checks the slot's occupancy, generates the RAM address from the slot's base and offset, and settles contention. Pop data arrives one cycle after the pop is granted.

Every slot publishes its full flag, its empty flag and its word count. A configuration write loads a slot's base address and depth and clears that slot's pointers.

Top module: `pfp_top`

## Requirements
- R1: While `rst` is high at a clock edge, every slot is restored to the default partition: slot i starts at address 51*i and holds 51 words. After that edge, every count is 0, every `empty` bit is 1, every `full` bit is 0 and `rd_vld` is 0.
- R2: With `host_mode`=0 and the receive flag low, a request goes to slot equal to its endpoint index (0..3). The periodic select is ignored.
- R3: With `host_mode`=1 and the receive flag low, a request goes to slot 0 when the periodic select is 1 and to slot 1 when it is 0. The endpoint index is ignored.
- R4: A request with the receive flag high goes to slot 4 in either mode. Data pushed in one mode can be popped in the other.
- R5: Each slot returns words in the order they were pushed. The RAM address is (base + offset) mod 256, and the offset returns to 0 after depth-1.
- R6: A slot's count rises by one on each accepted push and falls by one on each accepted pop. Otherwise it holds unless the slot is reconfigured. `full` is 1 when count equals depth, and `empty` is 1 when count is 0.
- R7: A push to a full slot or a pop from an empty slot is not performed. It raises `push_err` or `pop_err` for that cycle, leaves the count unchanged and produces no `rd_vld`.
- R8: When a valid pop and a valid push arrive in the same cycle, the pop gets the RAM port. The push gets `push_stall` and is not performed. Any push to a full slot is reported as `push_err` rather than stalled.
- R9: A configuration write to slot `cfg_slot` (values 5..7 ignored) loads base and depth and sets that slot's count and offsets to 0. In that cycle, a push or pop aimed at the same slot gets its stall flag and is not performed. Other slots keep their contents.
- R10: `rd_vld` is high in exactly the cycle after `pop_ack`, and `rd_data` then holds the popped word.
- R11: A slot programmed with depth 0 reports both `full` and `empty` and rejects every push and pop with an error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host slot mapping, 0 = device mapping |
| cfg_we | input | 1 | Partition write strobe |
| cfg_slot | input | 3 | Slot being reprogrammed |
| cfg_base | input | 8 | New start address |
| cfg_depth | input | 9 | New depth in words (0..256) |
| push_req | input | 1 | Push request |
| push_rx | input | 1 | Push targets the receive FIFO |
| push_ep | input | 2 | Push endpoint index (device mode) |
| push_per | input | 1 | Push periodic select (host mode) |
| push_data | input | 32 | Word to push |
| push_ack | output | 1 | Push performed this cycle |
| push_stall | output | 1 | Push deferred; retry |
| push_err | output | 1 | Push rejected, slot full |
| pop_req | input | 1 | Pop request |
| pop_rx | input | 1 | Pop targets the receive FIFO |
| pop_ep | input | 2 | Pop endpoint index (device mode) |
| pop_per | input | 1 | Pop periodic select (host mode) |
| pop_ack | output | 1 | Pop performed this cycle |
| pop_stall | output | 1 | Pop deferred by reconfiguration |
| pop_err | output | 1 | Pop rejected, slot empty |
| rd_vld | output | 1 | `rd_data` valid |
| rd_data | output | 32 | Popped word |
| full | output | 5 | Per-slot full flags |
| empty | output | 5 | Per-slot empty flags |
| count | output | 45 | Per-slot word counts, 9 bits each, slot i at [9i+8:9i] |

## Verification
On every cycle, the assertions check the following:
- at most one RAM access is granted;
- a push that meets a granted pop is held off;
- read data follows a pop by exactly one cycle;
- counts move only when an access or configuration occurs;
- reset leaves every slot empty.

Only the bench's scenarios can show the rest: that the slot mapping is correct in each mode, that words come back in order across the address wrap at 255, that reconfiguration clears one slot without disturbing the others, and that data crosses a mode switch through the shared receive FIFO.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int N_IN      = 4;
    localparam int NF        = N_IN + 1;
    localparam int RX_SLOT   = NF - 1;
    localparam int SLOT_W    = $clog2(NF);
    localparam int EP_W      = $clog2(N_IN);
    localparam int CNT_W     = ADDR_W + 1;
    localparam int DEF_DEPTH = (1 << ADDR_W) / NF;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic            rx;
        logic [EP_W-1:0] ep;
        logic            per;
    } target_t;

    typedef struct packed {
        addr_t base;
        cnt_t  depth;
    } part_t;

    typedef enum logic [1:0] {
        RAM_IDLE  = 2'd0,
        RAM_WRITE = 2'd1,
        RAM_READ  = 2'd2
    } ram_op_e;

    function automatic slot_t slot_of(input logic host, input target_t t);
        if (t.rx)
            return slot_t'(RX_SLOT);
        if (host)
            return t.per ? slot_t'(0) : slot_t'(1);
        return slot_t'(t.ep);
    endfunction

    function automatic part_t default_part(input int idx);
        part_t p;
        p.base  = addr_t'(idx * DEF_DEPTH);
        p.depth = cnt_t'(DEF_DEPTH);
        return p;
    endfunction

    function automatic addr_t next_off(input addr_t off, input cnt_t depth);
        if ((cnt_t'(off) + cnt_t'(1)) >= depth)
            return '0;
        return off + addr_t'(1);
    endfunction
endpackage

// File: rtl/pfp_spram.sv
module pfp_spram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        else if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/pfp_slot_ctx.sv
module pfp_slot_ctx
    import pfp_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_load,
    input  part_t cfg_part,
    input  logic  do_push,
    input  logic  do_pop,
    output addr_t wr_addr,
    output addr_t rd_addr,
    output cnt_t  cnt,
    output logic  full,
    output logic  empty
);
    part_t part;
    addr_t wr_off;
    addr_t rd_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            part   <= default_part(IDX);
            wr_off <= '0;
            rd_off <= '0;
            cnt    <= '0;
        end else if (cfg_load) begin
            part   <= cfg_part;
            wr_off <= '0;
            rd_off <= '0;
            cnt    <= '0;
        end else begin
            if (do_push)
                wr_off <= next_off(wr_off, part.depth);
            if (do_pop)
                rd_off <= next_off(rd_off, part.depth);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + cnt_t'(1);
                2'b01:   cnt <= cnt - cnt_t'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign wr_addr = part.base + wr_off;
    assign rd_addr = part.base + rd_off;
    assign full    = (cnt == part.depth);
    assign empty   = (cnt == '0);
endmodule

// File: rtl/pfp_arb.sv
module pfp_arb
    import pfp_pkg::*;
(
    input  logic    push_req,
    input  logic    pop_req,
    input  logic    push_full,
    input  logic    pop_empty,
    input  logic    push_cfg_hit,
    input  logic    pop_cfg_hit,
    output logic    push_go,
    output logic    pop_go,
    output logic    push_stall,
    output logic    push_err,
    output logic    pop_stall,
    output logic    pop_err,
    output ram_op_e op
);
    always_comb begin
        pop_stall  = pop_req && pop_cfg_hit;
        pop_err    = pop_req && !pop_cfg_hit && pop_empty;
        pop_go     = pop_req && !pop_cfg_hit && !pop_empty;

        push_stall = 1'b0;
        push_err   = 1'b0;
        push_go    = 1'b0;
        if (push_req) begin
            if (push_cfg_hit)
                push_stall = 1'b1;
            else if (push_full)
                push_err = 1'b1;
            else if (pop_go)
                push_stall = 1'b1;
            else
                push_go = 1'b1;
        end

        if (pop_go)
            op = RAM_READ;
        else if (push_go)
            op = RAM_WRITE;
        else
            op = RAM_IDLE;
    end
endmodule

// File: rtl/pfp_top.sv
module pfp_top
    import pfp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_mode,
    input  logic                  cfg_we,
    input  logic [SLOT_W-1:0]     cfg_slot,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [CNT_W-1:0]      cfg_depth,
    input  logic                  push_req,
    input  logic                  push_rx,
    input  logic [EP_W-1:0]       push_ep,
    input  logic                  push_per,
    input  logic [DATA_W-1:0]     push_data,
    output logic                  push_ack,
    output logic                  push_stall,
    output logic                  push_err,
    input  logic                  pop_req,
    input  logic                  pop_rx,
    input  logic [EP_W-1:0]       pop_ep,
    input  logic                  pop_per,
    output logic                  pop_ack,
    output logic                  pop_stall,
    output logic                  pop_err,
    output logic                  rd_vld,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NF-1:0]         full,
    output logic [NF-1:0]         empty,
    output logic [NF*CNT_W-1:0]   count
);
    target_t push_tgt;
    target_t pop_tgt;
    slot_t   push_slot;
    slot_t   pop_slot;
    part_t   cfg_part;

    addr_t   wr_addr_a [NF];
    addr_t   rd_addr_a [NF];
    cnt_t    cnt_a     [NF];

    logic    push_go;
    logic    pop_go;
    ram_op_e op;
    addr_t   ram_addr;

    assign push_tgt  = '{rx: push_rx, ep: push_ep, per: push_per};
    assign pop_tgt   = '{rx: pop_rx,  ep: pop_ep,  per: pop_per};
    assign push_slot = slot_of(host_mode, push_tgt);
    assign pop_slot  = slot_of(host_mode, pop_tgt);
    assign cfg_part  = '{base: cfg_base, depth: cfg_depth};

    for (genvar i = 0; i < NF; i++) begin : g_slot
        pfp_slot_ctx #(.IDX(i)) u_ctx (
            .clk      (clk),
            .rst      (rst),
            .cfg_load (cfg_we && (cfg_slot == slot_t'(i))),
            .cfg_part (cfg_part),
            .do_push  (push_go && (push_slot == slot_t'(i))),
            .do_pop   (pop_go && (pop_slot == slot_t'(i))),
            .wr_addr  (wr_addr_a[i]),
            .rd_addr  (rd_addr_a[i]),
            .cnt      (cnt_a[i]),
            .full     (full[i]),
            .empty    (empty[i])
        );
        assign count[i*CNT_W +: CNT_W] = cnt_a[i];
    end

    pfp_arb u_arb (
        .push_req     (push_req),
        .pop_req      (pop_req),
        .push_full    (full[push_slot]),
        .pop_empty    (empty[pop_slot]),
        .push_cfg_hit (cfg_we && (cfg_slot == push_slot)),
        .pop_cfg_hit  (cfg_we && (cfg_slot == pop_slot)),
        .push_go      (push_go),
        .pop_go       (pop_go),
        .push_stall   (push_stall),
        .push_err     (push_err),
        .pop_stall    (pop_stall),
        .pop_err      (pop_err),
        .op           (op)
    );

    assign ram_addr = (op == RAM_READ) ? rd_addr_a[pop_slot] : wr_addr_a[push_slot];

    pfp_spram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (op == RAM_WRITE),
        .re    (op == RAM_READ),
        .addr  (ram_addr),
        .wdata (push_data),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_vld <= 1'b0;
        else
            rd_vld <= pop_go;
    end

    assign push_ack = push_go;
    assign pop_ack  = pop_go;
endmodule

// File: rtl/pfp_chk.sv
module pfp_chk
    import pfp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic                push_req,
    input logic                push_ack,
    input logic                push_stall,
    input logic                push_err,
    input logic                pop_ack,
    input logic                pop_err,
    input logic                rd_vld,
    input logic [NF-1:0]       empty,
    input logic [NF*CNT_W-1:0] count
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (empty == '1 && count == '0 && !rd_vld));

    // R8
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(push_ack && pop_ack));

    // R8
    pop_first_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_ack) |-> (push_stall || push_err));

    // R10
    rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pop_ack |=> rd_vld);

    // R10
    no_spurious_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !pop_ack |=> !rd_vld);

    // R7
    pop_reject_chk: assert property (@(posedge clk) disable iff (rst)
        pop_err |=> !rd_vld);

    // R7
    push_reject_chk: assert property (@(posedge clk) disable iff (rst)
        push_err |-> !push_ack);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!push_ack && !pop_ack && !cfg_we) |=> $stable(count));

    // R6
    push_moves_chk: assert property (@(posedge clk) disable iff (rst)
        push_ack |=> !$stable(count));
endmodule

bind pfp_top pfp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .push_req   (push_req),
    .push_ack   (push_ack),
    .push_stall (push_stall),
    .push_err   (push_err),
    .pop_ack    (pop_ack),
    .pop_err    (pop_err),
    .rd_vld     (rd_vld),
    .empty      (empty),
    .count      (count)
);

// File: tb/tb_pfp_top.sv
module tb_pfp_top;
    import pfp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                host_mode = 1'b0;
    logic                cfg_we = 1'b0;
    logic [SLOT_W-1:0]   cfg_slot = '0;
    logic [ADDR_W-1:0]   cfg_base = '0;
    logic [CNT_W-1:0]    cfg_depth = '0;
    logic                push_req = 1'b0, push_rx = 1'b0, push_per = 1'b0;
    logic [EP_W-1:0]     push_ep = '0;
    logic [DATA_W-1:0]   push_data = '0;
    logic                pop_req = 1'b0, pop_rx = 1'b0, pop_per = 1'b0;
    logic [EP_W-1:0]     pop_ep = '0;
    logic                push_ack, push_stall, push_err;
    logic                pop_ack, pop_stall, pop_err;
    logic                rd_vld;
    logic [DATA_W-1:0]   rd_data;
    logic [NF-1:0]       full, empty;
    logic [NF*CNT_W-1:0] count;

    pfp_top dut (.*);

    int total = 0;
    int bad = 0;
    logic [2:0]  s_push, s_pop;
    logic        s_rv;
    logic [31:0] s_rd;

    typedef struct packed {
        logic        host;
        logic        pu;
        logic        pu_rx;
        logic [1:0]  pu_ep;
        logic        pu_per;
        logic [31:0] pu_d;
        logic        po;
        logic        po_rx;
        logic [1:0]  po_ep;
        logic        po_per;
        logic [2:0]  e_push;   // {ack, stall, err}
        logic [2:0]  e_pop;    // {ack, stall, err}
        logic [31:0] e_rd;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0,1'b1,1'b0,2'd0,1'b0,32'hA0A0_0000,1'b0,1'b0,2'd0,1'b0,3'b100,3'b000,32'h0},           // R2
        '{1'b0,1'b1,1'b0,2'd1,1'b1,32'hB1B1_0001,1'b0,1'b0,2'd0,1'b0,3'b100,3'b000,32'h0},           // R2
        '{1'b0,1'b1,1'b1,2'd2,1'b0,32'hC2C2_0002,1'b0,1'b0,2'd0,1'b0,3'b100,3'b000,32'h0},           // R4
        '{1'b0,1'b0,1'b0,2'd0,1'b0,32'h0,1'b1,1'b0,2'd0,1'b1,3'b000,3'b100,32'hA0A0_0000},           // R2 R10
        '{1'b0,1'b0,1'b0,2'd0,1'b0,32'h0,1'b1,1'b0,2'd1,1'b0,3'b000,3'b100,32'hB1B1_0001},           // R2
        '{1'b0,1'b0,1'b0,2'd0,1'b0,32'h0,1'b1,1'b0,2'd0,1'b0,3'b000,3'b001,32'h0},                   // R7
        '{1'b1,1'b1,1'b0,2'd2,1'b1,32'hD3D3_0003,1'b0,1'b0,2'd0,1'b0,3'b100,3'b000,32'h0},           // R3
        '{1'b1,1'b1,1'b0,2'd3,1'b0,32'hE4E4_0004,1'b0,1'b0,2'd0,1'b0,3'b100,3'b000,32'h0},           // R3
        '{1'b1,1'b0,1'b0,2'd0,1'b0,32'h0,1'b1,1'b1,2'd3,1'b0,3'b000,3'b100,32'hC2C2_0002},           // R4
        '{1'b1,1'b0,1'b0,2'd0,1'b0,32'h0,1'b1,1'b0,2'd0,1'b0,3'b000,3'b100,32'hE4E4_0004},           // R3
        '{1'b1,1'b1,1'b0,2'd0,1'b0,32'hF5F5_0005,1'b1,1'b0,2'd0,1'b1,3'b010,3'b100,32'hD3D3_0003},   // R8
        '{1'b0,1'b0,1'b0,2'd0,1'b0,32'h0,1'b1,1'b0,2'd1,1'b0,3'b000,3'b001,32'h0}                    // R8
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CNT_W-1:0] cnt_of(input int i);
        return count[i*CNT_W +: CNT_W];
    endfunction

    task automatic step(input logic host, input logic cw, input logic [2:0] cs,
                        input logic [7:0] cb, input logic [8:0] cd,
                        input logic pu, input logic pu_rx_i, input logic [1:0] pu_ep_i,
                        input logic pu_per_i, input logic [31:0] pu_d,
                        input logic po, input logic po_rx_i, input logic [1:0] po_ep_i,
                        input logic po_per_i);
        @(negedge clk);
        host_mode = host; cfg_we = cw; cfg_slot = cs; cfg_base = cb; cfg_depth = cd;
        push_req = pu; push_rx = pu_rx_i; push_ep = pu_ep_i; push_per = pu_per_i;
        push_data = pu_d;
        pop_req = po; pop_rx = po_rx_i; pop_ep = po_ep_i; pop_per = po_per_i;
        #1;
        s_push = {push_ack, push_stall, push_err};
        s_pop  = {pop_ack, pop_stall, pop_err};
        @(posedge clk);
        #1;
        s_rv = rd_vld;
        s_rd = rd_data;
        cfg_we = 1'b0; push_req = 1'b0; pop_req = 1'b0;
    endtask

    task automatic push_dev(input logic [1:0] ep, input logic [31:0] d);
        step(1'b0, 1'b0, 3'd0, 8'd0, 9'd0, 1'b1, 1'b0, ep, 1'b0, d, 1'b0, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic pop_dev(input logic [1:0] ep);
        step(1'b0, 1'b0, 3'd0, 8'd0, 9'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0, ep, 1'b0);
    endtask

    task automatic cfg(input logic [2:0] s, input logic [7:0] b, input logic [8:0] d);
        step(1'b0, 1'b1, s, b, d, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 empty", 64'(empty), 64'h1F);
        chk("R1 full", 64'(full), 64'h0);
        chk("R1 count", 64'(count), 64'h0);
        chk("R1 rd_vld", 64'(rd_vld), 64'h0);

        foreach (VEC[k]) begin
            step(VEC[k].host, 1'b0, 3'd0, 8'd0, 9'd0,
                 VEC[k].pu, VEC[k].pu_rx, VEC[k].pu_ep, VEC[k].pu_per, VEC[k].pu_d,
                 VEC[k].po, VEC[k].po_rx, VEC[k].po_ep, VEC[k].po_per);
            chk($sformatf("R2/R3/R4/R8 vec%0d push flags", k), 64'(s_push), 64'(VEC[k].e_push));
            chk($sformatf("R7/R8 vec%0d pop flags", k), 64'(s_pop), 64'(VEC[k].e_pop));
            chk($sformatf("R10 vec%0d rd_vld", k), 64'(s_rv), 64'(VEC[k].e_pop[2]));
            if (VEC[k].e_pop[2])
                chk($sformatf("R5 vec%0d rd_data", k), 64'(s_rd), 64'(VEC[k].e_rd));
        end

        // R5 R6 R7 R9: slot 2 at base 254, depth 4, wraps past address 255
        cfg(3'd2, 8'd254, 9'd4);
        chk("R9 count cleared", 64'(cnt_of(2)), 64'd0);
        for (int i = 0; i < 4; i++) begin
            push_dev(2'd2, 32'h5100 + i);
            chk("R5 push ack", 64'(s_push), 64'b100);
        end
        chk("R6 count 4", 64'(cnt_of(2)), 64'd4);
        chk("R6 full", 64'(full[2]), 64'd1);
        push_dev(2'd2, 32'hDEAD);
        chk("R7 push to full", 64'(s_push), 64'b001);
        chk("R7 count unchanged", 64'(cnt_of(2)), 64'd4);
        for (int i = 0; i < 4; i++) begin
            pop_dev(2'd2);
            chk("R5 order across wrap", 64'(s_rd), 64'(32'h5100 + i));
        end
        chk("R6 empty", 64'(empty[2]), 64'd1);

        // R9: reconfigure slot 3 while a push targets it; slot 1 untouched
        push_dev(2'd3, 32'h3333_0000);
        push_dev(2'd3, 32'h3333_0001);
        push_dev(2'd1, 32'h1111_0000);
        step(1'b0, 1'b1, 3'd3, 8'd100, 9'd10, 1'b1, 1'b0, 2'd3, 1'b0, 32'hBAD0,
             1'b0, 1'b0, 2'd0, 1'b0);
        chk("R9 push stalled by cfg", 64'(s_push), 64'b010);
        chk("R9 slot3 cleared", 64'(cnt_of(3)), 64'd0);
        chk("R9 other slot kept", 64'(cnt_of(1)), 64'd1);
        pop_dev(2'd1);
        chk("R9 other slot data", 64'(s_rd), 64'h1111_0000);

        // R11: depth zero
        cfg(3'd3, 8'd0, 9'd0);
        chk("R11 full and empty", 64'({full[3], empty[3]}), 64'b11);
        push_dev(2'd3, 32'h1);
        chk("R11 push rejected", 64'(s_push), 64'b001);
        pop_dev(2'd3);
        chk("R11 pop rejected", 64'(s_pop), 64'b001);
        chk("R11 no rd_vld", 64'(s_rv), 64'd0);

        // R1: reset again mid-run
        push_dev(2'd0, 32'h7);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 empty after reset", 64'(empty), 64'h1F);
        chk("R1 count after reset", 64'(count), 64'h0);
        chk("R1 full after reset", 64'(full), 64'h0);
        summary();
    end
endmodule